// File: doc/BRIEF.md
# Floppy Controller Head-Positioning Command Sequencer

This block accepts 8-bit command bytes from a host on a small address/data register bus and carries out the head-positioning part of a floppy disk controller. It covers return to track zero, seek to a target track, single steps (in, out, or repeating the last direction) and the force-interrupt command. It owns the track, sector and data registers, the remembered step direction and the status byte. It raises an interrupt line when a command finishes.

Mechanical time is modelled rather than measured. Each command loads a down-counter with a cost in microseconds. The cost is worked out from the number of tracks crossed and the verify and head-load flags. The counter advances only on a 1 MHz tick enable, and the command completes on the tick that brings it from one to zero. Data-transfer commands are decoded and timed so the status stays coherent, but no data moves through this block.

Top module: `fdc_cmd_seq`

## Requirements
- R1: Register addresses are 0 = command (write) / status (read), 1 = track, 2 = sector, 3 = data; track, sector and data read back what was written. Reset gives track 0, sector 1, data 0, irq low and status 0x04. Status bits: bit0 busy, bit1 data request, bit2 track zero, bit5 head loaded, bit7 not ready.
- R2: Command upper nibble 0x0 (restore) sets the track to 0 at once. It completes after STEP_US*max(old track,1) ticks, plus VERIFY_US if command bit 2 is set. Completion status is 0x24 and irq goes high.
- R3: Upper nibble 0x1 (seek) takes its target from the data register, clamped to TRACKS-1, and loads the target into the track register at once. It costs STEP_US*max(|target-old track|,1), plus VERIFY_US if bit 2 is set, plus HLOAD_US if bit 3 is set. Completion status is 0x20, with bit2 also set when the new track is 0.
- R4: Upper nibbles 0x4/0x5 (step in) store direction "in" and add one to the track. 0x6/0x7 (step out) store direction "out" and subtract one. 0x2/0x3 (step) move one track in the stored direction. The track is clamped to 0..TRACKS-1, and each step costs STEP_US. Completion status has bit2 set if the track is 0 and bit5 set if command bit 3 is set.
- R5: A seek stores direction "in" when the target is above the current track and "out" when it is below. An equal target leaves the direction unchanged. Reset direction is "in".
- R6: Writing any command other than force interrupt drives irq low and status to 0x01 (busy) on the next cycle.
- R7: Reading status (address 0 with the read strobe) drives irq low. If a completion falls in the same cycle as the read, irq ends high.
- R8: Force interrupt (upper nibble 0xD) sets status to 0x24 if the track is 0 and to 0x00 otherwise. With a low nibble of 0 it also drops irq and cancels any pending completion, so that no completion follows.
- R9: Force interrupt with bit 3 set raises irq on the next cycle and sets status bit1 (data request).
- R10: While media_present is low, bit7 is ORed into every status read.
- R11: Upper nibbles 0x8 to 0xC, 0xE and 0xF (data commands) leave the track unchanged. They complete after STEP_US ticks with status 0x04 on track 0 and 0x00 elsewhere.
- R12: The delay counter moves only on cycles where tick_us is high; with tick_us held low a busy command never completes.
- R13: A command written in the cycle its predecessor would complete takes priority. The old completion is dropped and irq stays low until the new command ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | 1 MHz tick enable for the delay counter |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (matters only for the status clear) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| media_present | input | 1 | High when a medium is inserted |
| irq | output | 1 | Command-complete interrupt |

## Verification
Two pairs of events can land on the same clock edge. A completion can meet a status read, and a completion can meet a new command write. The bench provokes the first by counting exactly one tick short of a restore's cost and then issuing the status read, so that the read strobe sits on the completion edge. The read must return busy and irq must still be high afterwards. It provokes the second the same way with a command write on the completion edge, and judges that irq stays low, status reads busy and the new command later completes with its own cost.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

  typedef enum logic [2:0] {
    OP_RESTORE,
    OP_SEEK,
    OP_STEP,
    OP_STEP_IN,
    OP_STEP_OUT,
    OP_DATA,
    OP_FORCE
  } fdc_op_e;

  // status bit positions
  localparam int ST_BUSY  = 0;
  localparam int ST_DRQ   = 1;
  localparam int ST_TRK0  = 2;
  localparam int ST_HLOAD = 5;
  localparam int ST_NRDY  = 7;

  // register addresses
  localparam logic [1:0] A_CMD = 2'd0;
  localparam logic [1:0] A_TRK = 2'd1;
  localparam logic [1:0] A_SEC = 2'd2;
  localparam logic [1:0] A_DAT = 2'd3;

  // tracks crossed by a seek, never less than one
  function automatic int unsigned track_gap(input logic [7:0] a, input logic [7:0] b);
    int unsigned d;
    if (a > b) d = 32'(a) - 32'(b);
    else       d = 32'(b) - 32'(a);
    if (d == 0) d = 1;
    return d;
  endfunction

  function automatic logic [7:0] seek_target(input logic [7:0] req, input logic [7:0] last);
    return (req > last) ? last : req;
  endfunction

  // one step in the given direction, kept inside 0..last
  function automatic logic [7:0] step_track(input logic [7:0] cur, input logic dir_in,
                                            input logic [7:0] last);
    logic [7:0] nxt;
    if (dir_in) nxt = (cur >= last) ? last : cur + 8'd1;
    else        nxt = (cur == 8'd0) ? 8'd0 : cur - 8'd1;
    if (nxt > last) nxt = last;
    return nxt;
  endfunction

  // microseconds a command keeps the head busy
  function automatic int unsigned cmd_cost(input fdc_op_e op, input logic [7:0] trk,
                                           input logic [7:0] tgt, input logic vflag,
                                           input logic hflag, input int unsigned step_us,
                                           input int unsigned ver_us, input int unsigned hl_us);
    int unsigned c;
    case (op)
      OP_RESTORE: begin
        c = step_us * ((trk == 8'd0) ? 32'd1 : 32'(trk));
        if (vflag) c = c + ver_us;
      end
      OP_SEEK: begin
        c = step_us * track_gap(trk, tgt);
        if (vflag) c = c + ver_us;
        if (hflag) c = c + hl_us;
      end
      default: c = step_us;
    endcase
    return c;
  endfunction

  // status left behind when a timed command ends
  function automatic logic [7:0] done_status(input fdc_op_e op, input logic [7:0] trk,
                                             input logic hflag);
    logic [7:0] s;
    s = '0;
    s[ST_TRK0] = (trk == 8'd0);
    case (op)
      OP_RESTORE: s[ST_HLOAD] = 1'b1;
      OP_SEEK:    s[ST_HLOAD] = 1'b1;
      OP_DATA:    s[ST_HLOAD] = 1'b0;
      default:    s[ST_HLOAD] = hflag;
    endcase
    return s;
  endfunction

  function automatic logic [7:0] force_status(input logic [7:0] trk, input logic drq);
    logic [7:0] s;
    s = '0;
    s[ST_TRK0]  = (trk == 8'd0);
    s[ST_HLOAD] = (trk == 8'd0);
    s[ST_DRQ]   = drq;
    return s;
  endfunction

endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
  import fdc_pkg::*;
(
  input  logic [7:0] cmd,
  output fdc_op_e    op,
  output logic [2:0] cls,
  output logic       hflag,
  output logic       vflag,
  output logic       fi_cancel,
  output logic       fi_raise
);

  always_comb begin
    case (cmd[7:4])
      4'h0:         begin op = OP_RESTORE;  cls = 3'd1; end
      4'h1:         begin op = OP_SEEK;     cls = 3'd1; end
      4'h2, 4'h3:   begin op = OP_STEP;     cls = 3'd1; end
      4'h4, 4'h5:   begin op = OP_STEP_IN;  cls = 3'd1; end
      4'h6, 4'h7:   begin op = OP_STEP_OUT; cls = 3'd1; end
      4'h8, 4'h9,
      4'hA, 4'hB:   begin op = OP_DATA;     cls = 3'd2; end
      4'hD:         begin op = OP_FORCE;    cls = 3'd4; end
      default:      begin op = OP_DATA;     cls = 3'd3; end
    endcase
  end

  assign hflag     = cmd[3];
  assign vflag     = cmd[2];
  assign fi_cancel = (cmd[3:0] == 4'h0);
  assign fi_raise  = cmd[3];

endmodule

// File: rtl/fdc_delay_timer.sv
module fdc_delay_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             cancel,
  input  logic             suppress,
  output logic             pending,
  output logic             done
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count;
  logic             last_tick;

  assign last_tick = pending && tick && (count == ONE);
  assign done      = last_tick && !suppress;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      pending <= 1'b0;
    end else if (load) begin
      count   <= load_val;
      pending <= (load_val != '0);
    end else if (cancel) begin
      count   <= '0;
      pending <= 1'b0;
    end else if (pending && tick) begin
      count <= count - ONE;
      if (count == ONE) pending <= 1'b0;
    end
  end

  AST_TMR_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> pending); // R12
  AST_TMR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !tick && !load && !cancel) |=> (pending && $stable(count))); // R12
  AST_TMR_DONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tick && pending)); // R12
  AST_TMR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (count != '0)); // R12

endmodule

// File: rtl/fdc_head_pos.sv
module fdc_head_pos
  import fdc_pkg::*;
#(
  parameter int LAST_TRK = 79
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  fdc_op_e    op,
  input  logic [7:0] tgt,
  input  logic       host_wr,
  input  logic [7:0] host_val,
  output logic [7:0] track,
  output logic       dir_in
);

  localparam logic [7:0] LAST_V = 8'(LAST_TRK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      track  <= 8'd0;
      dir_in <= 1'b1;
    end else if (go) begin
      case (op)
        OP_RESTORE: track <= 8'd0;
        OP_SEEK: begin
          track <= tgt;
          if (tgt > track)      dir_in <= 1'b1;
          else if (tgt < track) dir_in <= 1'b0;
        end
        OP_STEP: track <= step_track(track, dir_in, LAST_V);
        OP_STEP_IN: begin
          dir_in <= 1'b1;
          track  <= step_track(track, 1'b1, LAST_V);
        end
        OP_STEP_OUT: begin
          dir_in <= 1'b0;
          track  <= step_track(track, 1'b0, LAST_V);
        end
        default: track <= track;
      endcase
    end else if (host_wr) begin
      track <= host_val;
    end
  end

  AST_RESTORE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_RESTORE) |=> (track == 8'd0)); // R2
  AST_STEP_IN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_STEP_IN && track == LAST_V) |=> (track == LAST_V)); // R4
  AST_STEP_OUT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_STEP_OUT) |=> !dir_in); // R4
  AST_SEEK_DIR_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_SEEK && tgt > track) |=> dir_in); // R5

endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
  import fdc_pkg::*;
#(
  parameter int TRACKS    = 80,
  parameter int STEP_US   = 6000,
  parameter int VERIFY_US = 30000,
  parameter int HLOAD_US  = 80000,
  parameter int CNT_W     = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       media_present,
  output logic       irq
);

  localparam int         LAST_TRK = TRACKS - 1;
  localparam logic [7:0] LAST_V   = 8'(LAST_TRK);

  // decoded command
  fdc_op_e    dec_op;
  logic [2:0] dec_cls;
  logic       dec_h, dec_v, dec_fi_cancel, dec_fi_raise;

  // registers
  logic [7:0] stat_q, sector_q, data_q;
  logic [7:0] track_q;
  logic       dir_in_q;
  fdc_op_e    run_op_q;
  logic       run_h_q;

  // named events
  logic evt_cmd, evt_stat_rd, evt_go_pos, evt_go_data, evt_go_fi, evt_fi_raise;
  logic evt_load, evt_cancel, evt_done, tmr_pending;
  logic [7:0] seek_tgt;
  logic [CNT_W-1:0] cost;

  assign evt_cmd      = bus_wr && (bus_addr == A_CMD);
  assign evt_stat_rd  = bus_rd && (bus_addr == A_CMD);
  assign evt_go_pos   = evt_cmd && (dec_cls == 3'd1);
  assign evt_go_data  = evt_cmd && ((dec_cls == 3'd2) || (dec_cls == 3'd3));
  assign evt_go_fi    = evt_cmd && (dec_cls == 3'd4);
  assign evt_fi_raise = evt_go_fi && dec_fi_raise;
  assign evt_load     = evt_go_pos || evt_go_data;
  assign evt_cancel   = evt_go_fi && dec_fi_cancel;

  assign seek_tgt = seek_target(data_q, LAST_V);
  assign cost     = CNT_W'(cmd_cost(dec_op, track_q, seek_tgt, dec_v, dec_h,
                                    STEP_US, VERIFY_US, HLOAD_US));

  fdc_cmd_decode u_dec (
    .cmd       (bus_wdata),
    .op        (dec_op),
    .cls       (dec_cls),
    .hflag     (dec_h),
    .vflag     (dec_v),
    .fi_cancel (dec_fi_cancel),
    .fi_raise  (dec_fi_raise)
  );

  fdc_delay_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_us),
    .load     (evt_load),
    .load_val (cost),
    .cancel   (evt_cancel),
    .suppress (evt_cmd),
    .pending  (tmr_pending),
    .done     (evt_done)
  );

  fdc_head_pos #(.LAST_TRK(LAST_TRK)) u_head (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (evt_go_pos),
    .op       (dec_op),
    .tgt      (seek_tgt),
    .host_wr  (bus_wr && (bus_addr == A_TRK)),
    .host_val (bus_wdata),
    .track    (track_q),
    .dir_in   (dir_in_q)
  );

  // command context kept for completion
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_op_q <= OP_RESTORE;
      run_h_q  <= 1'b0;
    end else if (evt_load) begin
      run_op_q <= dec_op;
      run_h_q  <= dec_h;
    end
  end

  // status byte
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= 8'h04;
    end else if (evt_go_fi) begin
      stat_q <= force_status(track_q, dec_fi_raise);
    end else if (evt_load) begin
      stat_q <= 8'h01;
    end else if (evt_done) begin
      stat_q <= done_status(run_op_q, track_q, run_h_q);
    end
  end

  // interrupt line: raise beats any clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)            irq <= 1'b0;
    else if (evt_fi_raise) irq <= 1'b1;
    else if (evt_cmd)      irq <= 1'b0;
    else if (evt_done)     irq <= 1'b1;
    else if (evt_stat_rd)  irq <= 1'b0;
  end

  // plain host registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sector_q <= 8'd1;
      data_q   <= 8'd0;
    end else if (bus_wr) begin
      if (bus_addr == A_SEC) sector_q <= bus_wdata;
      if (bus_addr == A_DAT) data_q   <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CMD: begin
        bus_rdata = stat_q;
        if (!media_present) bus_rdata[ST_NRDY] = 1'b1;
      end
      A_TRK:   bus_rdata = track_q;
      A_SEC:   bus_rdata = sector_q;
      default: bus_rdata = data_q;
    endcase
  end

  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> irq); // R7
  AST_CMD_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_cmd && !evt_fi_raise) |=> !irq); // R6
  AST_CMD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_load |=> (stat_q == 8'h01)); // R6
  AST_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_stat_rd && !evt_cmd && !evt_done) |=> !irq); // R7
  AST_FI_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fi_raise |=> (irq && stat_q[ST_DRQ])); // R9
  AST_FI_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cancel |=> (!tmr_pending && !irq)); // R8
  AST_CMD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cmd |-> !evt_done); // R13
  AST_SEEK_TRACK_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_go_pos && dec_op == OP_SEEK) |=> (track_q <= LAST_V)); // R3

endmodule

// File: tb/sim_fdc_cmd_seq.sv
module sim_fdc_cmd_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_us = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       media_present = 1'b1;
  logic       irq;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  fdc_cmd_seq #(.STEP_US(6), .VERIFY_US(30), .HLOAD_US(80)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .media_present(media_present), .irq(irq)
  );

  // {track, data, command, ticks, track after, status after}
  localparam int NV = 15;
  localparam logic [55:0] VEC [NV] = '{
    {8'd5,  8'd0,   8'h00, 16'd30,  8'd0,  8'h24},  // R2 restore
    {8'd0,  8'd0,   8'h04, 16'd36,  8'd0,  8'h24},  // R2 restore+verify from 0
    {8'd10, 8'd20,  8'h10, 16'd60,  8'd20, 8'h20},  // R3 seek in
    {8'd30, 8'd200, 8'h1C, 16'd404, 8'd79, 8'h20},  // R3 clamp + verify + load
    {8'd7,  8'd7,   8'h10, 16'd6,   8'd7,  8'h20},  // R3 same track
    {8'd40, 8'd0,   8'h18, 16'd320, 8'd0,  8'h24},  // R3 R5 seek out to 0
    {8'd12, 8'd0,   8'h20, 16'd6,   8'd11, 8'h00},  // R5 step reuses out
    {8'd79, 8'd0,   8'h40, 16'd6,   8'd79, 8'h00},  // R4 step in clamp
    {8'd3,  8'd0,   8'h30, 16'd6,   8'd4,  8'h00},  // R4 step reuses in
    {8'd1,  8'd0,   8'h60, 16'd6,   8'd0,  8'h04},  // R4 step out
    {8'd0,  8'd0,   8'h68, 16'd6,   8'd0,  8'h24},  // R4 step out clamp, head flag
    {8'd0,  8'd0,   8'h20, 16'd6,   8'd0,  8'h04},  // R4 step out again at 0
    {8'd9,  8'd0,   8'h80, 16'd6,   8'd9,  8'h00},  // R11 data command
    {8'd0,  8'd0,   8'hF0, 16'd6,   8'd0,  8'h04},  // R11 data command on 0
    {8'd50, 8'd30,  8'h14, 16'd150, 8'd30, 8'h20}   // R3 R5 seek out + verify
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 3000) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    peek(2'd0, v); check("R1 reset status", v, 8'h04);
    peek(2'd1, v); check("R1 reset track", v, 0);
    peek(2'd2, v); check("R1 reset sector", v, 1);
    peek(2'd3, v); check("R1 reset data", v, 0);
    check("R1 reset irq", irq, 0);
    bus_write(2'd2, 8'd9);
    peek(2'd2, v); check("R1 sector readback", v, 9);

    // table walk
    for (int i = 0; i < NV; i++) begin
      bus_write(2'd1, VEC[i][55:48]);
      bus_write(2'd3, VEC[i][47:40]);
      bus_write(2'd0, VEC[i][39:32]);
      #0 check($sformatf("R6 vec%0d irq after write", i), irq, 0);
      v = bus_rdata; check($sformatf("R6 vec%0d busy", i), v, 8'h01);
      wait_irq(n);
      check($sformatf("vec%0d ticks", i), n, int'(VEC[i][31:16]));
      peek(2'd1, v); check($sformatf("vec%0d track", i), v, VEC[i][15:8]);
      peek(2'd0, v); check($sformatf("vec%0d status", i), v, VEC[i][7:0]);
      bus_read(2'd0, v);
      check($sformatf("R7 vec%0d irq after read", i), irq, 0);
    end

    // R12: no progress without tick
    tick_us = 1'b0;
    bus_write(2'd1, 8'd5);
    bus_write(2'd0, 8'h40);
    repeat (40) @(posedge clk);
    #1 check("R12 held irq", irq, 0);
    peek(2'd0, v); check("R12 held busy", v, 8'h01);
    tick_us = 1'b1;
    wait_irq(n); check("R12 resumed ticks", n, 6);
    bus_read(2'd0, v);

    // R8: cancel a long seek
    bus_write(2'd1, 8'd0);
    bus_write(2'd3, 8'd50);
    bus_write(2'd0, 8'h10);
    repeat (20) @(posedge clk);
    bus_write(2'd0, 8'hD0);
    check("R8 irq after cancel", irq, 0);
    peek(2'd0, v); check("R8 status off track 0", v, 8'h00);
    repeat (400) @(posedge clk);
    #1 check("R8 no late completion", irq, 0);
    peek(2'd1, v); check("R8 track kept", v, 50);

    // R9: immediate interrupt
    bus_write(2'd0, 8'hD8);
    check("R9 irq raised", irq, 1);
    peek(2'd0, v); check("R9 drq status", v, 8'h02);
    bus_read(2'd0, v);
    check("R7 read clears forced irq", irq, 0);

    // R8 on track 0, R10 not ready
    bus_write(2'd1, 8'd0);
    bus_write(2'd0, 8'hD0);
    peek(2'd0, v); check("R8 status on track 0", v, 8'h24);
    media_present = 1'b0;
    peek(2'd0, v); check("R10 not ready", v, 8'hA4);
    media_present = 1'b1;

    // R7: completion and status read on one edge
    bus_write(2'd1, 8'd3);
    bus_write(2'd0, 8'h00);
    repeat (17) @(posedge clk);
    bus_read(2'd0, v);
    check("R7 read in completion cycle sees busy", v, 8'h01);
    check("R7 irq survives read", irq, 1);
    bus_read(2'd0, v);
    check("R7 status after", v, 8'h24);
    check("R7 second read clears", irq, 0);

    // R13: command on completion edge
    bus_write(2'd1, 8'd5);
    bus_write(2'd3, 8'd6);
    bus_write(2'd0, 8'h40);
    repeat (5) @(posedge clk);
    bus_write(2'd0, 8'h10);
    check("R13 irq low", irq, 0);
    v = bus_rdata; check("R13 busy", v, 8'h01);
    wait_irq(n); check("R13 new cost", n, 6);
    peek(2'd0, v); check("R13 seek status", v, 8'h20);
    peek(2'd1, v); check("R13 track", v, 6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule